// File: doc/BRIEF.md
# Vector Type Register Update Unit

This unit owns the vector-type control register and applies two kinds of update that decoded instructions request. A persistent modify request scales the element width and the register grouping by the same power of two, so their ratio and the vector length stay the same. The same request also rewrites the tail and mask policy bits. A request that would push either field out of range is rejected, and the rejection raises an illegal-instruction pulse.

A prefix request loads a 10-bit transient field. That field can override the element width and grouping for the next vector instruction only. It stays in place until a vector instruction commits. Traps and interrupts therefore do not lose it, and a resumed instruction still sees the override. Downstream logic reads the effective width and grouping, which are selected between the stored fields and the override.

Top module: `vtype_update_unit`

## Requirements
- R1: After reset, vtype_o is all zeros. This gives width code 0 (8-bit) and grouping code 0 (x1), with no override active and illegal_o low.
- R2: A modify request uses payload bits [2:0] as a signed log2 delta. After the next clock edge, the width code (vtype_o[5:3], 0..3 = 8/16/32/64 bits) and the grouping code (vtype_o[2:0], two's complement -3..3 = 1/8..8) have both moved by that delta.
- R3: A modify request fails if the new width code falls outside 0..3 or the new grouping code falls outside -3..3. On a failure, vtype_o[7:0] is unchanged and illegal_o is high for exactly the one cycle after the request.
- R4: On a successful modify, payload bit 3 is written to the tail policy bit vtype_o[6] and payload bit 4 to the mask policy bit vtype_o[7].
- R5: Payload bits [14:5] are reserved and have no effect on the result of a modify.
- R6: A prefix request writes pfx_bits_i into vtype_o[30:21] at the next clock edge.
- R7: While transient bit 6 (vtype_o[27]) is set, eff_sew_o is taken from vtype_o[26:24], eff_lmul_o from vtype_o[23:21], and ovr_active_o is high. Otherwise eff_sew_o and eff_lmul_o follow the stored fields.
- R8: Only a commit clears the transient field, and the field holds its value until then. When a prefix request and a commit arrive in the same cycle, the prefix is written.
- R9: When a modify request and a commit arrive in the same cycle, the modify is applied and the transient field is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_valid_i | input | 1 | Persistent modify request |
| mod_payload_i | input | 15 | Modify payload: [4:0] active field, [14:5] reserved |
| pfx_valid_i | input | 1 | Transient prefix request |
| pfx_bits_i | input | 10 | Transient field value |
| commit_i | input | 1 | A vector instruction commits |
| vtype_o | output | 32 | Vector-type register |
| eff_sew_o | output | 3 | Effective element width code |
| eff_lmul_o | output | 3 | Effective grouping code |
| ovr_active_o | output | 1 | Transient override in effect |
| illegal_o | output | 1 | Illegal modification pulse |

## Verification
Every register update and the illegal pulse become visible after the first rising edge following the request. The effective outputs are combinational from the register, so they change in that same cycle. The driver presents each request at a falling edge and queues the expected state for the next rising edge. The monitor compares 1 ns after that edge, so each expected item is matched to the exact cycle it belongs to. An idle cycle after every failure confirms that the illegal pulse lasts only one cycle.

// File: rtl/vtu_pkg.sv
package vtu_pkg;
  localparam int XLEN     = 32;
  localparam int SEW_W    = 3;
  localparam int LMUL_W   = 3;
  localparam int DELTA_W  = 3;
  localparam int PFX_W    = 10;
  localparam int PLD_W    = 15;
  localparam int LMUL_LSB = 0;
  localparam int SEW_LSB  = LMUL_LSB + LMUL_W;
  localparam int VTA_BIT  = SEW_LSB + SEW_W;
  localparam int VMA_BIT  = VTA_BIT + 1;
  localparam int PFX_LSB  = 21;
  localparam int OVR_EN   = LMUL_W + SEW_W;  // enable bit inside transient field
  localparam int SEW_MAX  = 3;
  localparam int LMUL_MAX = 3;
endpackage

// File: rtl/vtu_ratio_scale.sv
module vtu_ratio_scale #(
  parameter int SEW_W    = 3,
  parameter int LMUL_W   = 3,
  parameter int DELTA_W  = 3,
  parameter int SEW_MAX  = 3,
  parameter int LMUL_MAX = 3
) (
  input  logic [SEW_W-1:0]   sew_i,
  input  logic [LMUL_W-1:0]  lmul_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic [SEW_W-1:0]   sew_o,
  output logic [LMUL_W-1:0]  lmul_o,
  output logic               ok_o
);
  localparam int SW = SEW_W + 2;
  localparam int LW = LMUL_W + 2;
  localparam logic signed [SW-1:0] S_HI = SW'(SEW_MAX);
  localparam logic signed [LW-1:0] L_HI = LW'(LMUL_MAX);
  localparam logic signed [LW-1:0] L_LO = -LW'(LMUL_MAX);

  logic signed [SW-1:0] s_sum;
  logic signed [LW-1:0] l_sum;

  always_comb begin
    s_sum = $signed({2'b00, sew_i}) + $signed({{(SW-DELTA_W){delta_i[DELTA_W-1]}}, delta_i});
    l_sum = $signed({{2{lmul_i[LMUL_W-1]}}, lmul_i})
          + $signed({{(LW-DELTA_W){delta_i[DELTA_W-1]}}, delta_i});
  end

  assign ok_o   = (s_sum >= 0) && (s_sum <= S_HI) && (l_sum >= L_LO) && (l_sum <= L_HI);
  assign sew_o  = s_sum[SEW_W-1:0];
  assign lmul_o = l_sum[LMUL_W-1:0];
endmodule

// File: rtl/vtu_override_sel.sv
module vtu_override_sel #(
  parameter int SEW_W  = 3,
  parameter int LMUL_W = 3,
  parameter int PFX_W  = 10,
  parameter int OVR_EN = 6
) (
  input  logic [PFX_W-1:0]  pfx_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic [LMUL_W-1:0] lmul_i,
  output logic [SEW_W-1:0]  eff_sew_o,
  output logic [LMUL_W-1:0] eff_lmul_o,
  output logic              ovr_o
);
  assign ovr_o      = pfx_i[OVR_EN];
  assign eff_lmul_o = ovr_o ? pfx_i[LMUL_W-1:0] : lmul_i;
  assign eff_sew_o  = ovr_o ? pfx_i[LMUL_W +: SEW_W] : sew_i;
endmodule

// File: rtl/vtype_update_unit.sv
module vtype_update_unit
  import vtu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_valid_i,
  input  logic [PLD_W-1:0] mod_payload_i,
  input  logic             pfx_valid_i,
  input  logic [PFX_W-1:0] pfx_bits_i,
  input  logic             commit_i,
  output logic [XLEN-1:0]  vtype_o,
  output logic [SEW_W-1:0] eff_sew_o,
  output logic [LMUL_W-1:0] eff_lmul_o,
  output logic             ovr_active_o,
  output logic             illegal_o
);
  logic [XLEN-1:0]   vt_q, vt_d;
  logic              ill_q, ill_d;
  logic [SEW_W-1:0]  sew_new;
  logic [LMUL_W-1:0] lmul_new;
  logic              scale_ok;
  logic              rsv_unused;

  // rs1/rd portions of the payload are reserved
  assign rsv_unused = ^mod_payload_i[PLD_W-1:5];

  vtu_ratio_scale #(
    .SEW_W(SEW_W), .LMUL_W(LMUL_W), .DELTA_W(DELTA_W),
    .SEW_MAX(SEW_MAX), .LMUL_MAX(LMUL_MAX)
  ) u_scale (
    .sew_i  (vt_q[SEW_LSB +: SEW_W]),
    .lmul_i (vt_q[LMUL_LSB +: LMUL_W]),
    .delta_i(mod_payload_i[DELTA_W-1:0]),
    .sew_o  (sew_new),
    .lmul_o (lmul_new),
    .ok_o   (scale_ok)
  );

  vtu_override_sel #(
    .SEW_W(SEW_W), .LMUL_W(LMUL_W), .PFX_W(PFX_W), .OVR_EN(OVR_EN)
  ) u_sel (
    .pfx_i     (vt_q[PFX_LSB +: PFX_W]),
    .sew_i     (vt_q[SEW_LSB +: SEW_W]),
    .lmul_i    (vt_q[LMUL_LSB +: LMUL_W]),
    .eff_sew_o (eff_sew_o),
    .eff_lmul_o(eff_lmul_o),
    .ovr_o     (ovr_active_o)
  );

  // order: modify, then commit clear, then prefix write
  always_comb begin
    vt_d  = vt_q;
    ill_d = 1'b0;
    if (mod_valid_i) begin
      if (scale_ok) begin
        vt_d[SEW_LSB +: SEW_W]   = sew_new;
        vt_d[LMUL_LSB +: LMUL_W] = lmul_new;
        vt_d[VTA_BIT]            = mod_payload_i[3];
        vt_d[VMA_BIT]            = mod_payload_i[4];
      end else begin
        ill_d = 1'b1;
      end
    end
    if (commit_i)    vt_d[PFX_LSB +: PFX_W] = '0;
    if (pfx_valid_i) vt_d[PFX_LSB +: PFX_W] = pfx_bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vt_q  <= '0;
      ill_q <= 1'b0;
    end else begin
      vt_q  <= vt_d;
      ill_q <= ill_d;
    end
  end

  assign vtype_o   = vt_q;
  assign illegal_o = ill_q;

  logic signed [SEW_W+1:0] ratio_now;
  assign ratio_now = $signed({2'b00, vt_q[SEW_LSB +: SEW_W]})
                   - $signed({{2{vt_q[LMUL_LSB+LMUL_W-1]}}, vt_q[LMUL_LSB +: LMUL_W]});

  a_r2_ratio_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_now == $past(ratio_now));

  a_r3_fail_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> vt_q[VMA_BIT:0] == $past(vt_q[VMA_BIT:0]));

  a_r3_fail_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_valid_i && !scale_ok) |=> illegal_o);

  a_r3_width_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vt_q[SEW_LSB +: SEW_W] <= SEW_W'(SEW_MAX));

  a_r6_prefix_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfx_valid_i |=> vt_q[PFX_LSB +: PFX_W] == $past(pfx_bits_i));

  a_r8_commit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !pfx_valid_i) |=> vt_q[PFX_LSB +: PFX_W] == '0);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !pfx_valid_i) |=> $stable(vt_q[PFX_LSB +: PFX_W]));

  a_r7_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_active_o |-> (eff_sew_o == vt_q[PFX_LSB+LMUL_W +: SEW_W]
                      && eff_lmul_o == vt_q[PFX_LSB +: LMUL_W]));
endmodule

// File: tb/sim_vtype_update_unit.sv
module sim_vtype_update_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mv = 1'b0, pv = 1'b0, cm = 1'b0;
  logic [14:0] pl = '0;
  logic [9:0]  pb = '0;
  logic [31:0] vt;
  logic [2:0]  es, el;
  logic        ovr, ill;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] vt;
    logic [2:0]  es;
    logic [2:0]  el;
    logic        ovr;
    logic        ill;
    string       tag;
  } item_t;
  item_t exp_q[$];

  int         m_sew = 0, m_lmul = 0;
  logic       m_vta = 0, m_vma = 0;
  logic [9:0] m_pfx = '0;

  always #5 clk = ~clk;

  vtype_update_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mod_valid_i(mv), .mod_payload_i(pl),
    .pfx_valid_i(pv), .pfx_bits_i(pb), .commit_i(cm),
    .vtype_o(vt), .eff_sew_o(es), .eff_lmul_o(el),
    .ovr_active_o(ovr), .illegal_o(ill)
  );

  task automatic op(input logic m, input logic [14:0] p, input logic v,
                    input logic [9:0] b, input logic c, input string tag);
    item_t it;
    logic  bad;
    @(negedge clk);
    mv = m; pl = p; pv = v; pb = b; cm = c;
    bad = 1'b0;
    if (m) begin
      int d  = $signed(p[2:0]);
      int ns = m_sew + d;
      int nl = m_lmul + d;
      if (ns >= 0 && ns <= 3 && nl >= -3 && nl <= 3) begin
        m_sew = ns; m_lmul = nl; m_vta = p[3]; m_vma = p[4];
      end else bad = 1'b1;
    end
    if (c) m_pfx = '0;
    if (v) m_pfx = b;
    it.vt  = {1'b0, m_pfx, 13'b0, m_vma, m_vta, 3'(m_sew), 3'(m_lmul)};
    it.ovr = m_pfx[6];
    it.es  = m_pfx[6] ? m_pfx[5:3] : 3'(m_sew);
    it.el  = m_pfx[6] ? m_pfx[2:0] : 3'(m_lmul);
    it.ill = bad;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    op(1'b0, '0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        n_run++;
        if (vt !== it.vt || es !== it.es || el !== it.el || ovr !== it.ovr || ill !== it.ill) begin
          n_fail++;
          $display("FAIL %s: got vt=%h sew=%0d lmul=%0d ovr=%b ill=%b exp vt=%h sew=%0d lmul=%0d ovr=%b ill=%b",
                   it.tag, vt, es, el, ovr, ill, it.vt, it.es, it.el, it.ovr, it.ill);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_run++;  // R1 reset state
    if (vt !== 32'h0 || es !== 3'd0 || el !== 3'd0 || ovr !== 1'b0 || ill !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got vt=%h sew=%0d lmul=%0d ovr=%b ill=%b exp all zero", vt, es, el, ovr, ill);
    end
    op(1, 15'b00000_00000_01_001, 0, '0, 0, "R2 R4 up by one, tail set");
    op(1, 15'b00000_00000_01_010, 0, '0, 0, "R2 up by two to 64/x8");
    op(1, 15'b00000_00000_10_001, 0, '0, 0, "R3 width past 64 rejected");
    idle("R3 pulse lasts one cycle");
    op(1, 15'b11111_11111_10_101, 0, '0, 0, "R5 R2 down by three, reserved ones");
    op(1, 15'b00000_00000_00_111, 0, '0, 0, "R3 width below 8 rejected");
    idle("R3 pulse ends");
    op(1, 15'b00000_00000_10_011, 0, '0, 0, "R4 mask set, up by three");
    op(1, 15'b00000_00000_00_101, 0, '0, 0, "R4 policies cleared, down by three");
    op(1, 15'b10101_01010_00_001, 0, '0, 0, "R5 reserved pattern ignored");
    op(0, '0, 1, 10'b101_1_010_111, 0, "R6 R7 prefix with override");
    idle("R8 transient held without commit");
    op(0, '0, 0, '0, 1, "R8 commit clears transient");
    op(0, '0, 1, 10'b011_0_001_001, 0, "R7 disabled override passes stored");
    op(0, '0, 1, 10'b000_1_011_000, 1, "R8 prefix wins over commit");
    op(1, 15'b00000_00000_00_001, 0, '0, 1, "R9 modify with commit");
    op(1, 15'b00000_00000_00_100, 1, 10'b000_1_001_110, 0, "R3 R6 failed modify, prefix lands");
    idle("R7 override after failed modify");
    op(0, '0, 0, '0, 1, "R8 final commit");
    idle("R1 settle");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule